// File: doc/BRIEF.md
# Accumulator Processor Core with Interrupt Cycle

This block is a small processor core built around a single accumulator. It runs a fixed loop of fetch, execute and interrupt check. It talks to a synchronous, word-addressed memory whose read data arrives one cycle after the address. Each instruction word carries a 4-bit opcode in its top bits and a memory address in its low bits.

Three data operations are decoded: load the accumulator, store the accumulator, and add a memory word to the accumulator. A return-from-interrupt opcode is also decoded. Every other opcode does nothing.

The core has one interrupt request line and one acknowledge line. An interrupt is only taken in the interrupt-check cycle at the end of each instruction. When it is taken, the core saves the program counter and the accumulator, masks further requests, and continues fetching at a fixed handler address. The return instruction restores the saved program counter and accumulator and unmasks interrupts. The interrupted program then resumes where it stopped.

Top module: `acc_core`

## Requirements
- R1: While reset is held and in the first cycle after it, the core has `mem_we` low and `irq_ack` low, and it drives `mem_addr` to 0. The first instruction is fetched from address 0, the accumulator starts at 0 and interrupts start unmasked.
- R2: An instruction word is read from the address in the program counter. The program counter then advances by one. The opcode is bits [DW-1:DW-4] of the word and the operand address is bits [AW-1:0].
- R3: Opcode 1 replaces the accumulator with the memory word at the operand address.
- R4: Opcode 2 writes the accumulator to the operand address. `mem_we` is high for exactly one cycle and `mem_wdata` equals the accumulator.
- R5: Opcode 5 adds the memory word at the operand address to the accumulator, modulo 2^DW.
- R6: Opcodes 0, 3, 4, 6 to 14 perform no memory write and leave the accumulator unchanged.
- R7: Opcodes 1 and 5 take 5 cycles and every other opcode takes 4 cycles. A store drives `mem_we` in the third cycle of its instruction.
- R8: In the check cycle at the end of an instruction, if `irq` is high and interrupts are unmasked, `irq_ack` is high for that one cycle. The next fetch then comes from HANDLER_ADDR.
- R9: Once an interrupt is taken, no further `irq_ack` occurs until a return-from-interrupt has executed, even if `irq` stays high.
- R10: Opcode 15 restores the program counter and accumulator saved when the interrupt was taken, and unmasks interrupts.
- R11: If `irq` is low at the check cycle, execution continues at the next sequential instruction with no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | AW | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data (accumulator) |
| mem_rdata | input | DW | Memory read data, valid one cycle after the address |
| irq | input | 1 | Interrupt request, level sensitive |
| irq_ack | output | 1 | One-cycle pulse when an interrupt is taken |

## Verification
The bench builds the core with DW=16, AW=8 and HANDLER_ADDR=0xC0. With these values the bench can hold a model of the whole 256-word memory and inspect it after each program. The handler sits well away from the main program, so a wrong return address shows up as missing or misplaced stores. The 8-bit address field also leaves instruction bits [11:8] undecoded, and the bench programs set them to zero.

// File: rtl/acc_core.sv
module acc_core #(
  parameter int DW           = 16,
  parameter int AW           = 12,
  parameter int HANDLER_ADDR = 'hF00
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          irq,
  output logic          irq_ack
);
  localparam logic [AW-1:0] HVEC = HANDLER_ADDR[AW-1:0];
  localparam logic [3:0] OP_LD = 4'd1, OP_ST = 4'd2, OP_ADD = 4'd5, OP_RTI = 4'd15;

  typedef enum logic [2:0] {S_FETCH, S_FWAIT, S_EXEC, S_OWAIT, S_ICHK} state_t;

  state_t        state;
  logic [3:0]    op;
  logic [AW-1:0] ea, pc, sv_pc;
  logic [DW-1:0] acc, sv_acc;
  logic          ie;

  wire take = (state == S_ICHK) && irq && ie;

  assign irq_ack   = take;
  assign mem_addr  = (state == S_EXEC) ? ea : pc;
  assign mem_we    = (state == S_EXEC) && (op == OP_ST);
  assign mem_wdata = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_FETCH;
      op     <= '0;
      ea     <= '0;
      pc     <= '0;
      acc    <= '0;
      sv_pc  <= '0;
      sv_acc <= '0;
      ie     <= 1'b1;
    end else begin
      case (state)
        S_FETCH: state <= S_FWAIT;
        S_FWAIT: begin
          op    <= mem_rdata[DW-1 -: 4];
          ea    <= mem_rdata[AW-1:0];
          pc    <= pc + 1'b1;
          state <= S_EXEC;
        end
        S_EXEC: begin
          case (op)
            OP_LD, OP_ADD: state <= S_OWAIT;
            OP_RTI: begin
              pc    <= sv_pc;
              acc   <= sv_acc;
              ie    <= 1'b1;
              state <= S_ICHK;
            end
            default: state <= S_ICHK;
          endcase
        end
        S_OWAIT: begin
          acc   <= (op == OP_LD) ? mem_rdata : acc + mem_rdata;
          state <= S_ICHK;
        end
        S_ICHK: begin
          if (take) begin
            sv_pc  <= pc;
            sv_acc <= acc;
            pc     <= HVEC;
            ie     <= 1'b0;
          end
          state <= S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_FWAIT |=> pc == $past(pc) + 1'b1);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OWAIT && op == OP_LD) |=> acc == $past(mem_rdata));

  assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_add_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OWAIT && op == OP_ADD) |=> acc == DW'($past(acc) + $past(mem_rdata)));

  assert_ack_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!irq_ack && mem_addr == HVEC));

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie && !(state == S_EXEC && op == OP_RTI)) |=> !ie);

  assert_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC && op == OP_RTI) |=> (pc == $past(sv_pc) && acc == $past(sv_acc) && ie));
endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;
  localparam int DW = 16, AW = 8;
  localparam int HV = 'hC0;

  logic          clk = 0, rst_n = 0, irq = 0;
  logic [AW-1:0] mem_addr;
  logic          mem_we, irq_ack;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [DW-1:0] mem [256];

  int total = 0, fails = 0;
  int n_cyc, n_ack, first_we;

  always #10 clk = ~clk;

  acc_core #(.DW(DW), .AW(AW), .HANDLER_ADDR(HV)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq), .irq_ack(irq_ack));

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  localparam logic [47:0] VEC [6] = '{
    {16'h0005, 16'h0003, 16'h0008},
    {16'h0000, 16'h0000, 16'h0000},
    {16'hFFFF, 16'h0001, 16'h0000},
    {16'h8000, 16'h8000, 16'h0000},
    {16'h1234, 16'h4321, 16'h5555},
    {16'h7FFF, 16'h0001, 16'h8000}};

  function automatic logic [15:0] ins(input logic [3:0] o, input logic [7:0] a);
    return {o, 4'h0, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic start();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    n_cyc = 0; n_ack = 0; first_we = -1;
  endtask

  task automatic step();
    @(negedge clk);
    n_cyc++;
    if (irq_ack) n_ack++;
    if (mem_we && first_we < 0) first_we = n_cyc;
  endtask

  task automatic main_seq();
    // R1 reset state
    clear_mem();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 we in reset", 32'(mem_we), 0);
    chk("R1 ack in reset", 32'(irq_ack), 0);
    rst_n = 1;
    chk("R1 first fetch address", 32'(mem_addr), 0);

    // vector table: LD, ADD, ST without interrupts (R2 R3 R4 R5 R11)
    for (int v = 0; v < 6; v++) begin
      clear_mem();
      mem[0] = ins(4'd1, 8'h40);
      mem[1] = ins(4'd5, 8'h41);
      mem[2] = ins(4'd2, 8'h42);
      mem[8'h40] = VEC[v][47:32];
      mem[8'h41] = VEC[v][31:16];
      start();
      repeat (30) step();
      chk("R5 sum stored (R3 R4)", 32'(mem[8'h42]), 32'(VEC[v][15:0]));
      chk("R11 no ack without irq", n_ack, 0);
    end

    // R7 store timing after a load
    clear_mem();
    mem[0] = ins(4'd1, 8'h40);
    mem[1] = ins(4'd2, 8'h42);
    mem[8'h40] = 16'hA5A5;
    start();
    repeat (20) step();
    chk("R7 store strobe cycle after load", first_we, 7);
    chk("R4 stored accumulator", 32'(mem[8'h42]), 32'h0000A5A5);

    // R6 unlisted opcodes are no-ops, R7 four-cycle timing
    clear_mem();
    mem[0] = ins(4'd1, 8'h40);
    mem[1] = ins(4'd3, 8'h42);
    mem[2] = ins(4'd14, 8'h42);
    mem[3] = ins(4'd2, 8'h43);
    mem[8'h40] = 16'h1234;
    mem[8'h42] = 16'hBEEF;
    start();
    repeat (30) step();
    chk("R6 no write by unlisted opcode", 32'(mem[8'h42]), 32'h0000BEEF);
    chk("R6 accumulator unchanged", 32'(mem[8'h43]), 32'h00001234);
    chk("R7 no-op takes four cycles", first_we, 15);

    // R8 R9 R10 interrupt entry, mask and return
    clear_mem();
    mem[0] = ins(4'd1, 8'h40);
    mem[1] = ins(4'd5, 8'h41);
    mem[2] = ins(4'd2, 8'h42);
    mem[3] = ins(4'd2, 8'h43);
    mem[8'h40] = 16'd5;
    mem[8'h41] = 16'd3;
    mem[HV]     = ins(4'd1, 8'h50);
    mem[HV + 1] = ins(4'd2, 8'h51);
    mem[HV + 2] = ins(4'd15, 8'h00);
    mem[8'h50] = 16'd100;
    irq = 1;
    start();
    repeat (4) step();
    chk("R8 ack at first check cycle", 32'(irq_ack), 1);
    step();
    chk("R8 ack lasts one cycle", 32'(irq_ack), 0);
    chk("R8 fetch from handler", 32'(mem_addr), HV);
    repeat (10) step();
    irq = 0;
    repeat (45) step();
    chk("R9 single ack while masked", n_ack, 1);
    chk("R8 handler ran", 32'(mem[8'h51]), 32'd100);
    chk("R10 accumulator and pc restored", 32'(mem[8'h42]), 32'd8);
    chk("R10 program continued", 32'(mem[8'h43]), 32'd8);

    // R10 unmask: second request after return is taken again
    irq = 1;
    repeat (20) step();
    chk("R10 interrupts re-enabled", 32'(n_ack >= 2), 1);
    irq = 0;
  endtask

  task automatic watchdog();
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog (all R) actual=timeout expected=finish");
  endtask

  initial begin
    fork
      main_seq();
      watchdog();
    join_any
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule